// File: doc/BRIEF.md
# ADC Power-Up Configuration Sequencer

This block takes a multi-channel delta-sigma ADC from reset to a calibrated idle state with no processor involved. On a start pulse it captures the requested sample rate, reference choice, per-channel gain and input selection, and the enabled-channel mask. It checks that every requested setting is legal. It then drives a neighbouring SPI command engine through a fixed series of single-byte commands and register read-modify-write updates. At the end it raises `done`. If a setting is illegal, or the engine reports an error, it raises `fail` instead.

User values are translated into the converter's field codes inside the block. The sample rate in kSPS becomes a 3-bit divider code, and the gain factor becomes a 3-bit amplifier code. Offset calibration is forced to happen during initialization: the block issues the calibration request, starts conversion, waits a timed interval long enough for calibration to finish, and stops conversion again.

Each request is presented on a valid/acknowledge interface and held until the engine answers. A read-modify-write request carries an address, a bit mask and the new field bits. This leaves bits outside the targeted field untouched.

Top module: `adc_boot_seq`

## Requirements
- R1: A legal run issues, in this order: plain command 0x06 (reset), 0x11 (leave continuous read), the rate update, the reference update, the enabled-channel updates, the disabled-channel updates, then plain commands 0x1A (offset calibration), 0x08 (start) and 0x0A (stop). After the last acknowledge, `done` rises and no further request appears.
- R2: The rate update is a read-modify-write of address 0x01 with mask 0x07. The data is code 0, 1, 2, 3, 4, 5 or 6 for 64, 32, 16, 8, 4, 2 or 1 kSPS respectively.
- R3: The reference update is a read-modify-write of address 0x03. With the internal reference it uses mask 0xA0 and data 0x80, or 0xA0 when the 4.0 V level is chosen. With an external reference it uses mask 0x80 and data 0x00.
- R4: Each enabled channel n, in ascending order, gets a read-modify-write of address 5+n with mask 0x77. The data holds the gain code in bits [6:4] and the mux value in bits [2:0]. The gain codes are 1→1, 2→2, 4→4, 8→5 and 12→6.
- R5: After all enabled channels, each disabled channel n, in ascending order, gets a read-modify-write of address 5+n with mask 0x80 and data 0x80.
- R6: Any of the following makes `fail` rise on the second clock edge after start, and no request is ever issued:
  - a rate outside the seven listed values;
  - a gain outside {1,2,4,8,12} on an enabled channel;
  - a mux value outside {0,1,3,4} on an enabled channel.
- R7: Gain and mux inputs of disabled channels are not validated and do not appear in any request.
- R8: An acknowledge with the error flag set ends the sequence: `fail` rises, `done` stays low and no further request is issued.
- R9: Exactly RST_WAIT idle cycles separate the reset acknowledge from the next request. Exactly CAL_WAIT idle cycles separate the start acknowledge from the stop request.
- R10: A pending request keeps valid high and all its fields stable until acknowledged.
- R11: A start pulse while a sequence is running has no effect on the request stream.
- R12: After reset, `done`, `fail` and valid are low. `done` and `fail` hold their value until the next start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle pulse that begins a sequence when idle, done or failed |
| rate_ksps | input | 7 | Requested sample rate in kSPS |
| ref_internal | input | 1 | 1 selects the internal reference buffer |
| ref_4v | input | 1 | With internal reference, 1 selects 4.0 V, 0 selects 2.4 V |
| gain_sel | input | NCH*4 | Gain factor per channel, 4 bits each, channel 0 lowest |
| mux_sel | input | NCH*3 | Input selection per channel, 3 bits each |
| ch_enable | input | NCH | Enabled-channel mask |
| cmd_valid | output | 1 | Request pending toward the command engine |
| cmd_rmw | output | 1 | 1 for a register read-modify-write, 0 for a plain command byte |
| cmd_opcode | output | 8 | Plain command byte |
| cmd_addr | output | 5 | Register address for a read-modify-write |
| cmd_mask | output | 8 | Bits to replace in the register |
| cmd_wdata | output | 8 | New values of the masked bits |
| cmd_ack | input | 1 | One-cycle completion of the pending request |
| cmd_err | input | 1 | Qualifies cmd_ack as a failed request |
| done | output | 1 | Sequence completed |
| fail | output | 1 | Sequence rejected or aborted |

## Verification
The two functions that can fall in the same cycle are the acknowledge of one request and the presentation of the next. An acknowledge from the engine retires the request, and the very next cycle may already hold a new one without any idle gap. The bench provokes this with a zero-latency engine model, so acknowledges arrive the cycle after a request appears. It also runs with longer latencies that hold requests pending. The engine model pops each newly valid request from a queue of expected requests built from the requirements. It compares every field, and the same per-clock comparison checks `done` and `fail` against the model. A request retired twice, or skipped, then shows up as a field mismatch or as an unexpected request.

// File: rtl/adc_boot_seq.sv
module adc_boot_seq #(
  parameter int NCH      = 8,
  parameter int RST_WAIT = 18,
  parameter int CAL_WAIT = 1530000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       rate_ksps,
  input  logic             ref_internal,
  input  logic             ref_4v,
  input  logic [NCH*4-1:0] gain_sel,
  input  logic [NCH*3-1:0] mux_sel,
  input  logic [NCH-1:0]   ch_enable,
  output logic             cmd_valid,
  output logic             cmd_rmw,
  output logic [7:0]       cmd_opcode,
  output logic [4:0]       cmd_addr,
  output logic [7:0]       cmd_mask,
  output logic [7:0]       cmd_wdata,
  input  logic             cmd_ack,
  input  logic             cmd_err,
  output logic             done,
  output logic             fail
);

  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CMAX   = (RST_WAIT > CAL_WAIT) ? RST_WAIT : CAL_WAIT;
  localparam int TW     = $clog2(CMAX + 1);
  localparam int RW_END = RST_WAIT - 1;
  localparam int CA_END = CAL_WAIT - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RESET, S_RWAIT, S_SDC, S_RATE, S_REF, S_CHCFG,
    S_PWDN, S_OCAL, S_GO, S_CWAIT, S_HALT, S_DONE, S_FAIL
  } st_t;

  st_t              st, adv;
  logic [CW-1:0]    ch;
  logic [TW-1:0]    cnt;
  logic [6:0]       rate_q;
  logic             refi_q, ref4_q;
  logic [NCH*4-1:0] gain_q;
  logic [NCH*3-1:0] mux_q;
  logic [NCH-1:0]   en_q;
  logic             cfg_bad;
  logic             last_ch;
  logic [3:0]       rate_c, gain_c;
  logic [2:0]       mux_c;

  function automatic logic [3:0] rate_enc(input logic [6:0] r);
    case (r)
      7'd64:   return 4'd0;
      7'd32:   return 4'd1;
      7'd16:   return 4'd2;
      7'd8:    return 4'd3;
      7'd4:    return 4'd4;
      7'd2:    return 4'd5;
      7'd1:    return 4'd6;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [3:0] gain_enc(input logic [3:0] g);
    case (g)
      4'd1:    return 4'd1;
      4'd2:    return 4'd2;
      4'd4:    return 4'd4;
      4'd8:    return 4'd5;
      4'd12:   return 4'd6;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic mux_bad(input logic [2:0] m);
    return !(m == 3'd0 || m == 3'd1 || m == 3'd3 || m == 3'd4);
  endfunction

  assign done    = (st == S_DONE);
  assign fail    = (st == S_FAIL);
  assign last_ch = (ch == CW'(NCH - 1));
  assign rate_c  = rate_enc(rate_q);
  assign gain_c  = gain_enc(gain_q[int'(ch)*4 +: 4]);
  assign mux_c   = mux_q[int'(ch)*3 +: 3];

  always_comb begin
    cfg_bad = rate_c[3];
    for (int i = 0; i < NCH; i++)
      if (en_q[i])
        cfg_bad = cfg_bad | gain_enc(gain_q[i*4 +: 4])[3] | mux_bad(mux_q[i*3 +: 3]);
  end

  always_comb begin
    cmd_valid  = 1'b0;
    cmd_rmw    = 1'b0;
    cmd_opcode = 8'h00;
    cmd_addr   = 5'd0;
    cmd_mask   = 8'h00;
    cmd_wdata  = 8'h00;
    case (st)
      S_RESET: begin cmd_valid = 1'b1; cmd_opcode = 8'h06; end
      S_SDC:   begin cmd_valid = 1'b1; cmd_opcode = 8'h11; end
      S_OCAL:  begin cmd_valid = 1'b1; cmd_opcode = 8'h1A; end
      S_GO:    begin cmd_valid = 1'b1; cmd_opcode = 8'h08; end
      S_HALT:  begin cmd_valid = 1'b1; cmd_opcode = 8'h0A; end
      S_RATE: begin
        cmd_valid = 1'b1;
        cmd_rmw   = 1'b1;
        cmd_addr  = 5'd1;
        cmd_mask  = 8'h07;
        cmd_wdata = {5'd0, rate_c[2:0]};
      end
      S_REF: begin
        cmd_valid = 1'b1;
        cmd_rmw   = 1'b1;
        cmd_addr  = 5'd3;
        cmd_mask  = refi_q ? 8'hA0 : 8'h80;
        cmd_wdata = refi_q ? {2'b10, ref4_q, 5'd0} : 8'h00;
      end
      S_CHCFG: begin
        cmd_valid = en_q[ch];
        cmd_rmw   = 1'b1;
        cmd_addr  = 5'd5 + 5'(ch);
        cmd_mask  = 8'h77;
        cmd_wdata = {1'b0, gain_c[2:0], 1'b0, mux_c};
      end
      S_PWDN: begin
        cmd_valid = !en_q[ch];
        cmd_rmw   = 1'b1;
        cmd_addr  = 5'd5 + 5'(ch);
        cmd_mask  = 8'h80;
        cmd_wdata = 8'h80;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (st)
      S_RESET: adv = S_RWAIT;
      S_SDC:   adv = S_RATE;
      S_RATE:  adv = S_REF;
      S_REF:   adv = S_CHCFG;
      S_CHCFG: adv = last_ch ? S_PWDN : S_CHCFG;
      S_PWDN:  adv = last_ch ? S_OCAL : S_PWDN;
      S_OCAL:  adv = S_GO;
      S_GO:    adv = S_CWAIT;
      S_HALT:  adv = S_DONE;
      default: adv = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch     <= '0;
      cnt    <= '0;
      rate_q <= '0;
      refi_q <= 1'b0;
      ref4_q <= 1'b0;
      gain_q <= '0;
      mux_q  <= '0;
      en_q   <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL: begin
          if (start) begin
            rate_q <= rate_ksps;
            refi_q <= ref_internal;
            ref4_q <= ref_4v;
            gain_q <= gain_sel;
            mux_q  <= mux_sel;
            en_q   <= ch_enable;
            ch     <= '0;
            st     <= S_CHECK;
          end
        end
        S_CHECK: st <= cfg_bad ? S_FAIL : S_RESET;
        S_RWAIT: begin
          if (cnt == TW'(RW_END)) begin
            st  <= S_SDC;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CWAIT: begin
          if (cnt == TW'(CA_END)) begin
            st  <= S_HALT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if ((cmd_valid && cmd_ack) || !cmd_valid) begin
            if (cmd_valid && cmd_err) begin
              st <= S_FAIL;
            end else begin
              st  <= adv;
              cnt <= '0;
              if (st == S_CHCFG || st == S_PWDN)
                ch <= last_ch ? '0 : ch + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable({cmd_rmw, cmd_opcode, cmd_addr, cmd_mask, cmd_wdata})); // R10
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ack && cmd_err |=> fail && !done); // R8
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !cmd_valid && !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid); // R1
  AST_DATA_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_rmw |-> (cmd_wdata & ~cmd_mask) == 8'h00); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) && !$past(start) |-> done); // R12

endmodule

// File: tb/adc_boot_seq_tb_top.sv
module adc_boot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int RW  = 5;
  localparam int CW  = 30;

  typedef struct {
    bit rmw; logic [7:0] op; logic [4:0] addr; logic [7:0] mask; logic [7:0] data;
    int gap; string tag;
  } ent_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [6:0] rate_ksps = 7'd1;
  logic ref_internal = 1, ref_4v = 0;
  logic [NCH*4-1:0] gain_sel = '0;
  logic [NCH*3-1:0] mux_sel = '0;
  logic [NCH-1:0] ch_enable = '0;
  logic cmd_valid, cmd_rmw, cmd_ack = 0, cmd_err = 0, done, fail;
  logic [7:0] cmd_opcode, cmd_mask, cmd_wdata;
  logic [4:0] cmd_addr;

  adc_boot_seq #(.NCH(NCH), .RST_WAIT(RW), .CAL_WAIT(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_ksps(rate_ksps),
    .ref_internal(ref_internal), .ref_4v(ref_4v), .gain_sel(gain_sel),
    .mux_sel(mux_sel), .ch_enable(ch_enable), .cmd_valid(cmd_valid),
    .cmd_rmw(cmd_rmw), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_mask(cmd_mask), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
    .cmd_err(cmd_err), .done(done), .fail(fail));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  ent_t q[$];
  bit model_on = 0, exp_done = 0, exp_fail = 0;
  bit start_req = 0, stray_req = 0, stray = 0, bad_req = 0, bad_cnt = 0;
  bit pending = 0;
  int lat_cnt = 0, cur_lat = 0, err_at = -1, cmd_n = 0, gap = 0;
  int g[NCH], m[NCH];

  function automatic void chk(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endfunction

  function automatic int renc(int r);
    case (r) 64: return 0; 32: return 1; 16: return 2; 8: return 3;
      4: return 4; 2: return 5; 1: return 6; default: return -1; endcase
  endfunction

  function automatic int genc(int v);
    case (v) 1: return 1; 2: return 2; 4: return 4; 8: return 5;
      12: return 6; default: return -1; endcase
  endfunction

  function automatic void put(bit rmw, int op, int addr, int mask, int data, int gp, string tag);
    ent_t e;
    e.rmw = rmw; e.op = 8'(op); e.addr = 5'(addr); e.mask = 8'(mask);
    e.data = 8'(data); e.gap = gp; e.tag = tag;
    q.push_back(e);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      if (cmd_ack) begin
        if (cmd_err) exp_fail = 1;
        else if (q.size() == 0) exp_done = 1;
        cmd_ack = 0; cmd_err = 0; pending = 0;
      end
      if (bad_cnt) begin exp_fail = 1; bad_cnt = 0; end
      if (start) begin
        start = 0;
        if (!stray) begin exp_done = 0; exp_fail = 0; bad_cnt = bad_req; end
        stray = 0;
      end else if (start_req) begin
        start = 1; start_req = 0;
      end else if (stray_req) begin
        start = 1; stray = 1; stray_req = 0;
      end
      chk(done === exp_done && fail === exp_fail, "R12",
          $sformatf("done=%b fail=%b", done, fail),
          $sformatf("done=%b fail=%b", exp_done, exp_fail));
      if (!pending && cmd_valid) begin
        if (q.size() == 0) begin
          chk(0, "R11", $sformatf("request op=%h addr=%h", cmd_opcode, cmd_addr), "no request");
        end else begin
          ent_t e;
          bit ok;
          e = q.pop_front();
          ok = e.rmw ? (cmd_rmw && cmd_addr == e.addr && cmd_mask == e.mask && cmd_wdata == e.data)
                     : (!cmd_rmw && cmd_opcode == e.op);
          chk(ok, e.tag,
              $sformatf("rmw=%b op=%h addr=%h mask=%h data=%h", cmd_rmw, cmd_opcode, cmd_addr, cmd_mask, cmd_wdata),
              $sformatf("rmw=%b op=%h addr=%h mask=%h data=%h", e.rmw, e.op, e.addr, e.mask, e.data));
          if (e.gap >= 0)
            chk(gap == e.gap, "R9", $sformatf("gap=%0d", gap), $sformatf("gap=%0d", e.gap));
        end
        pending = 1; lat_cnt = cur_lat; gap = 0; cmd_n++;
      end else if (!cmd_valid) begin
        gap++;
      end
      if (pending && !cmd_ack) begin
        if (lat_cnt == 0) begin
          cmd_ack = 1;
          if (cmd_n - 1 == err_at) begin cmd_err = 1; q.delete(); end
        end else begin
          lat_cnt--;
        end
      end
    end
  end

  task automatic do_run(input int rate, input bit ri, input bit r4, input logic [NCH-1:0] en,
                        input int lat, input int eat, input bit stray_i);
    bit bad;
    int rc;
    rc = renc(rate);
    bad = (rc < 0);
    for (int i = 0; i < NCH; i++)
      if (en[i] && (genc(g[i]) < 0 || !(m[i] inside {0, 1, 3, 4}))) bad = 1;
    q.delete();
    if (!bad) begin
      put(0, 8'h06, 0, 0, 0, -1, "R1");
      put(0, 8'h11, 0, 0, 0, RW, "R9");
      put(1, 0, 1, 8'h07, rc, -1, "R2");
      if (ri) put(1, 0, 3, 8'hA0, r4 ? 8'hA0 : 8'h80, -1, "R3");
      else    put(1, 0, 3, 8'h80, 8'h00, -1, "R3");
      for (int i = 0; i < NCH; i++)
        if (en[i]) put(1, 0, 5 + i, 8'h77, (genc(g[i]) << 4) | m[i], -1, "R4");
      for (int i = 0; i < NCH; i++)
        if (!en[i]) put(1, 0, 5 + i, 8'h80, 8'h80, -1, "R5");
      put(0, 8'h1A, 0, 0, 0, -1, "R1");
      put(0, 8'h08, 0, 0, 0, -1, "R1");
      put(0, 8'h0A, 0, 0, 0, CW, "R9");
    end
    rate_ksps = 7'(rate); ref_internal = ri; ref_4v = r4; ch_enable = en;
    for (int i = 0; i < NCH; i++) begin
      gain_sel[i*4 +: 4] = 4'(g[i]);
      mux_sel[i*3 +: 3] = 3'(m[i]);
    end
    cur_lat = lat; err_at = eat; cmd_n = 0; bad_req = bad; start_req = 1;
    repeat (3) @(negedge clk);
    if (stray_i) begin
      repeat (8) @(negedge clk);
      stray_req = 1;
    end
    while (!(exp_done || exp_fail)) @(negedge clk);
    repeat (12) @(negedge clk);
    if (bad) chk(fail && !done && cmd_n == 0, "R6", $sformatf("fail=%b reqs=%0d", fail, cmd_n), "fail=1 reqs=0");
    else if (eat >= 0) chk(fail && !done && cmd_n == eat + 1, "R8",
                           $sformatf("fail=%b done=%b reqs=%0d", fail, done, cmd_n),
                           $sformatf("fail=1 done=0 reqs=%0d", eat + 1));
    else chk(done && q.size() == 0, "R1", $sformatf("done=%b left=%0d", done, q.size()), "done=1 left=0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !fail && !cmd_valid, "R12", $sformatf("%b%b%b", done, fail, cmd_valid), "000");
    model_on = 1;
    for (int i = 0; i < NCH; i++) begin g[i] = 1; m[i] = 0; end
    do_run(1, 1, 0, 4'b1111, 0, -1, 0);
    g = '{2, 4, 8, 12}; m = '{1, 3, 4, 0};
    do_run(64, 1, 1, 4'b1111, 2, -1, 0);
    g = '{12, 5, 8, 7}; m = '{4, 7, 3, 2};          // R7: channels 1 and 3 disabled, illegal values
    do_run(32, 0, 0, 4'b0101, 1, -1, 0);
    do_run(16, 0, 1, 4'b0000, 0, -1, 0);            // R5 all disabled
    g = '{1, 2, 4, 8}; m = '{0, 1, 3, 4};
    foreach (g[k]) ;
    do_run(8, 1, 0, 4'b1010, 0, -1, 0);
    do_run(4, 1, 1, 4'b0110, 1, -1, 0);
    do_run(2, 0, 0, 4'b1001, 0, -1, 0);
    do_run(3, 1, 0, 4'b1111, 0, -1, 0);             // R6 illegal rate
    do_run(0, 1, 0, 4'b1111, 0, -1, 0);             // R6 illegal rate
    g = '{1, 3, 4, 8};
    do_run(1, 1, 0, 4'b0010, 0, -1, 0);             // R6 illegal gain on enabled channel
    g = '{1, 2, 4, 8}; m = '{0, 0, 2, 0};
    do_run(1, 1, 0, 4'b0100, 0, -1, 0);             // R6 illegal mux on enabled channel
    m = '{0, 1, 3, 4};
    do_run(64, 1, 0, 4'b1111, 1, 3, 0);             // R8 error on fourth request
    do_run(64, 1, 0, 4'b1111, 0, 0, 0);             // R8 error on first request
    do_run(16, 1, 1, 4'b0011, 2, -1, 1);            // R11 start while running
    do_run(1, 1, 0, 4'b1111, 0, -1, 0);             // R12 flags cleared by new start
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule